// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address stream for a synchronous memory that serves four-word bursts. An external address is captured when either of two active-low start strobes is low at a rising clock edge. The captured address appears on the output in the next cycle. After that, the two lowest address bits step through a four-beat cycle, and they step only in cycles where the active-low advance input is low. A static order input chooses the stepping pattern. With order low the low bits count up modulo 4 from the start value. With order high they follow an exclusive-or pattern: the start value XOR the beat number.

Control is a two-state machine. `ST_IDLE` is the state after reset, before any address has been captured. `ST_BURST` holds a captured address. There are three named transitions. `T_START` goes from `ST_IDLE` to `ST_BURST` when either strobe is low. `T_RELOAD` goes from `ST_BURST` to `ST_BURST` when either strobe is low; it captures a fresh address and clears the beat. `T_STEP` goes from `ST_BURST` to `ST_BURST` when advance is low and neither strobe is low. Any other cycle holds the current state and all registers.

Either strobe may be used on every cycle, so the block also serves non-burst traffic with no added latency. When both strobes are low together, the processor-side strobe wins, and the winner is reported on `load_by_p`.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is 0, `beat` is 0, `burst_active` is 0 and `load_by_p` is 0.
- R2: If `strb_p_n` is low at an edge, then after that edge `addr_out` equals the sampled `addr_in`, `beat` is 0, `burst_active` is 1 and `load_by_p` is 1.
- R3: If `strb_c_n` is low at an edge while `strb_p_n` is high, the address is captured as in R2 and `load_by_p` is 0.
- R4: If both strobes are low at the same edge, the address is captured and `load_by_p` is 1, so the processor-side strobe takes priority.
- R5: In a burst, an edge with `adv_n` low and both strobes high advances `beat` by 1 modulo 4.
- R6: With `order_sel` = 0 (linear), `addr_out[1:0]` equals (start + `beat`) mod 4, for example 2,3,0,1.
- R7: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals start XOR `beat`, for example 1,0,3,2.
- R8: Address bits above bit 1 do not change during a burst. When advance continues after the fourth beat, the sequence wraps and repeats in the same order.
- R9: An edge with `adv_n` high and both strobes high leaves `addr_out` and `beat` unchanged.
- R10: `adv_n` is ignored at an edge where a strobe captures an address, so `beat` is 0 after that edge.
- R11: A new address may be captured at every edge. Each captured address appears on `addr_out` in the cycle after its own edge.
- R12: Before the first capture after reset, `adv_n` low has no effect: `addr_out` stays 0 and `burst_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External address, sampled on a capture |
| strb_p_n | input | 1 | Processor-side start strobe, active low, higher priority |
| strb_c_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static order: 0 = linear, 1 = interleaved |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat number within the burst, 0 to 3 |
| burst_active | output | 1 | High once an address has been captured |
| load_by_p | output | 1 | 1 if the last capture came from `strb_p_n` |

## Verification
Capture and advance are the two functions that can arrive at the same edge. The bench provokes this by holding `adv_n` low together with one strobe, or with both strobes, in the middle of a burst that has already stepped. It judges the outcome by checking that `beat` returns to 0 and that `addr_out` shows the new address unmodified, not the new address plus one step. Back-to-back captures with advance held low exercise the same collision on consecutive cycles.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bag_state_e;

    typedef enum logic [1:0] {
        T_NONE   = 2'd0,
        T_START  = 2'd1,
        T_RELOAD = 2'd2,
        T_STEP   = 2'd3
    } bag_trans_e;
endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          cap_by_p,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base_q,
    output logic          by_p_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            by_p_q <= 1'b0;
        end else if (cap_en) begin
            base_q <= addr_in;
            by_p_q <= cap_by_p;
        end
    end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [BEAT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import burst_addr_pkg::*;
(
    input  logic              interleave,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] cnt,
    output logic [BEAT_W-1:0] low_bits
);
    logic [BEAT_W-1:0] lin_bits;
    logic [BEAT_W-1:0] xor_bits;

    assign lin_bits = start + cnt;

    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
        assign xor_bits[i] = start[i] ^ cnt[i];
    end

    assign low_bits = interleave ? xor_bits : lin_bits;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          strb_p_n,
    input  logic          strb_c_n,
    input  logic          adv_n,
    input  logic          order_sel,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    beat,
    output logic          burst_active,
    output logic          load_by_p
);
    localparam int HI_W = AW - BEAT_W;

    bag_state_e        state_q, state_d;
    bag_trans_e        trans;
    logic              cap_en;
    logic              step_en;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] low_bits;

    assign cap_en = !strb_p_n || !strb_c_n;

    always_comb begin
        state_d = state_q;
        trans   = T_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (cap_en) begin
                    state_d = ST_BURST;
                    trans   = T_START;
                end
            end
            ST_BURST: begin
                if (cap_en) begin
                    trans = T_RELOAD;
                end else if (!adv_n) begin
                    trans = T_STEP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign step_en = (trans == T_STEP);

    bag_base_reg #(.AW(AW)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_by_p (!strb_p_n),
        .addr_in  (addr_in),
        .base_q   (base_q),
        .by_p_q   (load_by_p)
    );

    bag_beat_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap_en),
        .inc   (step_en),
        .cnt_q (cnt_q)
    );

    bag_order_map u_map (
        .interleave (order_sel),
        .start      (base_q[BEAT_W-1:0]),
        .cnt        (cnt_q),
        .low_bits   (low_bits)
    );

    always_comb begin
        addr_out     = {base_q[AW-1 -: HI_W], low_bits};
        beat         = cnt_q;
        burst_active = (state_q == ST_BURST);
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          strb_p_n,
    input logic          strb_c_n,
    input logic          adv_n,
    input logic          order_sel,
    input logic [AW-1:0] addr_out,
    input logic [1:0]    beat,
    input logic          burst_active,
    input logic          load_by_p
);
    logic nostrb;
    assign nostrb = strb_p_n && strb_c_n;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n || !strb_c_n) |=> (addr_out == $past(addr_in)) && beat == 2'd0 && burst_active);

    assert_p_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n) |=> load_by_p);

    assert_c_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_p_n && !strb_c_n) |=> !load_by_p);

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && nostrb && !adv_n) |=> beat == $past(beat) + 2'd1);

    assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && nostrb && !adv_n && !order_sel) |=>
        (order_sel || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    assert_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && nostrb && !adv_n && order_sel) |=>
        (!order_sel || (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat))));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nostrb |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nostrb && adv_n) |=> $stable(beat));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && nostrb) |=> !burst_active && addr_out == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_in      (addr_in),
    .strb_p_n     (strb_p_n),
    .strb_c_n     (strb_c_n),
    .adv_n        (adv_n),
    .order_sel    (order_sel),
    .addr_out     (addr_out),
    .beat         (beat),
    .burst_active (burst_active),
    .load_by_p    (load_by_p)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strb_p_n = 1'b1;
    logic          strb_c_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;
    logic          burst_active;
    logic          load_by_p;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strb_p_n(strb_p_n),
        .strb_c_n(strb_c_n), .adv_n(adv_n), .order_sel(order_sel),
        .addr_out(addr_out), .beat(beat), .burst_active(burst_active),
        .load_by_p(load_by_p)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit p_n, input bit c_n, input bit a_n, input logic [AW-1:0] a);
        @(negedge clk);
        strb_p_n = p_n; strb_c_n = c_n; adv_n = a_n; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strb_p_n = 1'b1; strb_c_n = 1'b1; adv_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int b, bit il);
        logic [1:0] lo;
        lo = il ? (base[1:0] ^ 2'(b)) : 2'(base[1:0] + 2'(b));
        return {base[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        do_reset();
        check(addr_out == '0 && beat == 0 && !burst_active && !load_by_p, "R1",
              {addr_out[15:0], 11'd0, beat, burst_active, load_by_p, 1'b0}, 32'h0);
    endtask

    task automatic t_idle_adv();
        for (int i = 0; i < 3; i++) begin
            step(1, 1, 0, 20'hABCDE);
            check(addr_out == '0 && !burst_active, "R12", addr_out, 0);
        end
    endtask

    task automatic t_burst(input bit il, input logic [AW-1:0] base, input string req);
        order_sel = il;
        step(0, 1, 1, base);
        check(addr_out == base && beat == 0 && burst_active && load_by_p, "R2", addr_out, base);
        for (int i = 1; i <= 6; i++) begin
            step(1, 1, 0, ~base);
            check(addr_out == expect_addr(base, i % 4, il), req, addr_out, expect_addr(base, i % 4, il));
            check(beat == 2'(i % 4), "R5", beat, i % 4);
            check(addr_out[AW-1:2] == base[AW-1:2], "R8", addr_out, base);
        end
    endtask

    task automatic t_hold();
        logic [AW-1:0] prev;
        logic [1:0] pb;
        prev = addr_out; pb = beat;
        for (int i = 0; i < 2; i++) begin
            step(1, 1, 1, 20'h55555);
            check(addr_out == prev && beat == pb, "R9", addr_out, prev);
        end
    endtask

    task automatic t_load_c();
        order_sel = 0;
        step(1, 0, 1, 20'h3C3C1);
        check(addr_out == 20'h3C3C1 && !load_by_p && beat == 0, "R3", {load_by_p, addr_out}, 20'h3C3C1);
    endtask

    task automatic t_both();
        step(1, 1, 0, 0);
        step(0, 0, 0, 20'h80002);
        check(addr_out == 20'h80002 && load_by_p, "R4", {load_by_p, addr_out}, {1'b1, 20'h80002});
        check(beat == 0, "R10", beat, 0);
    endtask

    task automatic t_adv_on_load();
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        step(1, 0, 0, 20'h11113);
        check(beat == 0 && addr_out == 20'h11113, "R10", addr_out, 20'h11113);
    endtask

    task automatic t_back_to_back();
        logic [AW-1:0] seq [4] = '{20'h00001, 20'hFFFFE, 20'h7A5A7, 20'h12340};
        for (int i = 0; i < 4; i++) begin
            step(i % 2, (i + 1) % 2, 0, seq[i]);
            check(addr_out == seq[i] && beat == 0, "R11", addr_out, seq[i]);
            check(load_by_p == !(i % 2), "R11", load_by_p, !(i % 2));
        end
    endtask

    initial begin
        t_reset();
        t_idle_adv();
        t_burst(0, 20'h12346, "R6");
        t_hold();
        t_burst(1, 20'h9ABC1, "R7");
        t_burst(1, 20'h0F0F2, "R7");
        t_load_c();
        t_both();
        t_adv_on_load();
        t_back_to_back();
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule